// File: doc/BRIEF.md
# Timer with Forced Output Compare

An 8-bit up-counter whose counting rate comes from a shared, free-running prescaler through a 3-bit clock-select field. Two compare channels, A and B, compare the count with their own compare register. On a match, each channel drives its waveform pin according to a 2-bit action field and raises a one-cycle match pulse. The counter either wraps freely at 255 or, in clear-on-compare mode, returns to zero after reaching compare value A.

Software can also make a channel act at once, without waiting for the count. It does this by writing a one to that channel's force bit in the control register. The force bit is a strobe and is never stored. It changes the pin exactly as a real match would. It never raises the match pulse and never disturbs the counter. It works only in the two plain modes (free-running and clear-on-compare). In every other mode, which is reserved for pulse-width generation, it is ignored.

All configuration goes through a small register bus with a combinational read path.

Top module: `fc_timer`

## Requirements
- R1: After reset every register reads zero, the count is 0, both waveform pins are low and both match pulses are low, so the timer is stopped.
- R2: The clock-select field (address 1, bits 2:0) behaves as follows. Code 0 stops the count. Code 1 advances it on every clock. Codes 2, 3, 4 and 5 advance it once every 8, 64, 256 and 1024 clocks of a free-running prescaler that only reset clears. Codes 6 and 7 stop the count.
- R3: In free-running mode (mode 000) the count increases by one on each tick and wraps from 255 to 0.
- R4: In clear-on-compare mode (mode 010), a tick that finds the count equal to compare register A (address 2) sets the count to 0 instead of incrementing it.
- R5: A tick that finds the count equal to compare register X (A at address 2, B at address 3) drives match pulse X high for exactly the following cycle, in every mode.
- R6: In a plain mode, a match applies the channel's action field to its pin on that clock edge. Channel A's field is address 0, bits 7:6, and channel B's is bits 5:4. The codes are 00 hold, 01 toggle, 10 drive low and 11 drive high.
- R7: Writing address 1 with bit 7 (A) or bit 6 (B) set, in a plain mode, applies that channel's current action on the write edge. It raises no match pulse and leaves the count unchanged, including in clear-on-compare mode.
- R8: In any mode other than 000 and 010, force bits are ignored and both pins hold their level.
- R9: Address 1 reads zero in bits 7:4, and writes to bits 5:4 are ignored. Address 0 reads zero in bits 3:2. Address 4 reads the count, and addresses 5 to 7 read zero. The mode is {address 1 bit 3, address 0 bits 1:0}.
- R10: A force strobe is gated by the mode as stored before the write that carries it, not by the mode bit written in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| match_a | output | 1 | Channel A match pulse |
| match_b | output | 1 | Channel B match pulse |

## Verification
The properties assume that bus_we, bus_addr and bus_wdata are always known values, so a force strobe is exactly a write with bit 7 or 6 set. They also assume that reset is applied synchronously for at least one edge before any check counts. The stimulus meets these assumptions. Every input is driven to a defined value from time zero and changes only on the falling edge. Each write lasts one cycle, and the address is parked on the count register between accesses. A second reset pulse is given only between test phases.

// File: rtl/fc_timer_pkg.sv
package fc_timer_pkg;

    localparam int BUS_W = 8;

    // register addresses
    localparam int REG_CFG  = 0;
    localparam int REG_CTL  = 1;
    localparam int REG_CMPA = 2;
    localparam int REG_CMPB = 3;
    localparam int REG_CNT  = 4;

    // prescaler tap positions (log2 of divide ratio)
    localparam int SH_8    = 3;
    localparam int SH_64   = 6;
    localparam int SH_256  = 8;
    localparam int SH_1024 = 10;

    localparam logic [2:0] MODE_FREE = 3'b000;
    localparam logic [2:0] MODE_CTC  = 3'b010;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } out_act_e;

    typedef enum logic [2:0] {
        SEL_OFF   = 3'd0,
        SEL_D1    = 3'd1,
        SEL_D8    = 3'd2,
        SEL_D64   = 3'd3,
        SEL_D256  = 3'd4,
        SEL_D1024 = 3'd5,
        SEL_X6    = 3'd6,
        SEL_X7    = 3'd7
    } clk_sel_e;

    typedef struct packed {
        out_act_e   act_a;
        out_act_e   act_b;
        logic [2:0] mode;
        clk_sel_e   sel;
    } cfg_t;

    function automatic logic next_level(out_act_e act, logic cur);
        case (act)
            ACT_TOGGLE: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

    function automatic logic is_plain(logic [2:0] mode);
        return (mode == MODE_FREE) || (mode == MODE_CTC);
    endfunction

endpackage

// File: rtl/fc_timer_presc.sv
module fc_timer_presc
    import fc_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    output logic     tick
);
    localparam int PRE_W = SH_1024;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        case (sel)
            SEL_D1:    tick = 1'b1;
            SEL_D8:    tick = &pre_q[SH_8-1:0];
            SEL_D64:   tick = &pre_q[SH_64-1:0];
            SEL_D256:  tick = &pre_q[SH_256-1:0];
            SEL_D1024: tick = &pre_q[SH_1024-1:0];
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/fc_timer_count.sv
module fc_timer_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear_at_top,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (clear_at_top && (cnt == top)) cnt <= '0;
            else                              cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fc_timer_chan.sv
module fc_timer_chan
    import fc_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  out_act_e         act,
    input  logic             plain,
    input  logic             force_i,
    output logic             wave,
    output logic             flag
);
    logic hit;
    logic fire;

    assign hit  = tick && (cnt == cmp);
    // a forced and a real match in the same cycle act once
    assign fire = plain && (hit || force_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
            flag <= 1'b0;
        end else begin
            flag <= hit;
            if (fire) wave <= next_level(act, wave);
        end
    end
endmodule

// File: rtl/fc_timer.sv
module fc_timer
    import fc_timer_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              wave_a,
    output logic              wave_b,
    output logic              match_a,
    output logic              match_b
);
    localparam int NCH = 2;

    cfg_t                       cfg_q;
    logic [NCH-1:0][CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]           cnt_q;
    logic                       tick;
    logic                       plain;
    logic                       ctl_wr;
    out_act_e                   act_v  [NCH];
    logic [NCH-1:0]             force_v;
    logic [NCH-1:0]             wave_v;
    logic [NCH-1:0]             flag_v;

    assign ctl_wr     = bus_we && (bus_addr == ADDR_W'(REG_CTL));
    assign plain      = is_plain(cfg_q.mode);
    assign act_v[0]   = cfg_q.act_a;
    assign act_v[1]   = cfg_q.act_b;
    assign force_v[0] = ctl_wr && bus_wdata[7];
    assign force_v[1] = ctl_wr && bus_wdata[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cmp_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADDR_W'(REG_CFG): begin
                    cfg_q.act_a     <= out_act_e'(bus_wdata[7:6]);
                    cfg_q.act_b     <= out_act_e'(bus_wdata[5:4]);
                    cfg_q.mode[1:0] <= bus_wdata[1:0];
                end
                ADDR_W'(REG_CTL): begin
                    cfg_q.mode[2] <= bus_wdata[3];
                    cfg_q.sel     <= clk_sel_e'(bus_wdata[2:0]);
                end
                ADDR_W'(REG_CMPA): cmp_q[0] <= bus_wdata[CNT_W-1:0];
                ADDR_W'(REG_CMPB): cmp_q[1] <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_CFG):  bus_rdata = {cfg_q.act_a, cfg_q.act_b, 2'b00, cfg_q.mode[1:0]};
            ADDR_W'(REG_CTL):  bus_rdata = {4'b0000, cfg_q.mode[2], cfg_q.sel};
            ADDR_W'(REG_CMPA): bus_rdata = BUS_W'(cmp_q[0]);
            ADDR_W'(REG_CMPB): bus_rdata = BUS_W'(cmp_q[1]);
            ADDR_W'(REG_CNT):  bus_rdata = BUS_W'(cnt_q);
            default: ;
        endcase
    end

    fc_timer_presc u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (cfg_q.sel),
        .tick (tick)
    );

    fc_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .clear_at_top (cfg_q.mode == MODE_CTC),
        .top          (cmp_q[0]),
        .cnt          (cnt_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fc_timer_chan #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cnt     (cnt_q),
            .cmp     (cmp_q[c]),
            .act     (act_v[c]),
            .plain   (plain),
            .force_i (force_v[c]),
            .wave    (wave_v[c]),
            .flag    (flag_v[c])
        );
    end

    assign wave_a  = wave_v[0];
    assign wave_b  = wave_v[1];
    assign match_a = flag_v[0];
    assign match_b = flag_v[1];
endmodule

// File: rtl/fc_timer_chk.sv
module fc_timer_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic [2:0]        sel,
    input logic [2:0]        mode,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp_a,
    input logic              match_a,
    input logic              wave_a,
    input logic              wave_b
);
    logic halted;
    logic top_seen;
    logic strobe_a;
    logic pwm_mode;

    assign halted   = (sel == 3'd0) || (sel == 3'd6) || (sel == 3'd7);
    assign top_seen = tick && (cnt == cmp_a);
    assign strobe_a = bus_we && (bus_addr == ADDR_W'(1)) && bus_wdata[7];
    assign pwm_mode = (mode != 3'b000) && (mode != 3'b010);

    AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(1)) |-> (bus_rdata[7:4] == 4'b0000)); // R9

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(cnt)); // R2

    AST_CTC_RETURN: assert property (@(posedge clk) disable iff (rst)
        ((mode == 3'b010) && top_seen) |=> (cnt == '0)); // R4

    AST_FORCE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (strobe_a && !top_seen) |=> !match_a); // R7

    AST_PWM_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        pwm_mode |=> ($stable(wave_a) && $stable(wave_b))); // R8
endmodule

bind fc_timer fc_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .sel       (cfg_q.sel),
    .mode      (cfg_q.mode),
    .tick      (tick),
    .cnt       (cnt_q),
    .cmp_a     (cmp_q[0]),
    .match_a   (match_a),
    .wave_a    (wave_a),
    .wave_b    (wave_b)
);

// File: tb/tb_fc_timer.sv
module tb_fc_timer;
    localparam int CLK_P = 10;
    localparam int WDOG  = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd4;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       wave_a, wave_b, match_a, match_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    fc_timer dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .wave_a(wave_a), .wave_b(wave_b),
        .match_a(match_a), .match_b(match_b)
    );

    // ---------------- behavioural reference ----------------
    int m_pre, m_cnt, m_sel, m_mode, m_acta, m_actb, m_cmpa, m_cmpb;
    bit m_wa, m_wb, m_fa, m_fb;

    function automatic bit act_lvl(int a, bit cur);
        if (a == 1) return !cur;
        if (a == 2) return 1'b0;
        if (a == 3) return 1'b1;
        return cur;
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return m_acta * 64 + m_actb * 16 + (m_mode % 4);
            1: return (m_mode / 4) * 8 + m_sel;
            2: return m_cmpa;
            3: return m_cmpb;
            4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit t, plain, ha, hb, sa, sb, nwa, nwb;
        int ncnt, dv;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_sel = 0; m_mode = 0; m_acta = 0; m_actb = 0;
            m_cmpa = 0; m_cmpb = 0; m_wa = 0; m_wb = 0; m_fa = 0; m_fb = 0;
        end else begin
            dv = (m_sel == 1) ? 1 : (m_sel == 2) ? 8 : (m_sel == 3) ? 64 :
                 (m_sel == 4) ? 256 : (m_sel == 5) ? 1024 : 0;
            t     = (dv != 0) && ((m_pre % dv) == dv - 1);
            plain = (m_mode == 0) || (m_mode == 2);
            ha    = t && (m_cnt == m_cmpa);
            hb    = t && (m_cnt == m_cmpb);
            sa    = bus_we && (bus_addr == 3'd1) && bus_wdata[7];
            sb    = bus_we && (bus_addr == 3'd1) && bus_wdata[6];
            nwa   = (plain && (ha || sa)) ? act_lvl(m_acta, m_wa) : m_wa;
            nwb   = (plain && (hb || sb)) ? act_lvl(m_actb, m_wb) : m_wb;
            ncnt  = m_cnt;
            if (t) ncnt = (m_mode == 2 && m_cnt == m_cmpa) ? 0 : (m_cnt + 1) % 256;
            m_wa = nwa; m_wb = nwb; m_fa = ha; m_fb = hb; m_cnt = ncnt;
            m_pre = (m_pre + 1) % 1024;
            if (bus_we) begin
                case (bus_addr)
                    3'd0: begin
                        m_acta = bus_wdata[7:6]; m_actb = bus_wdata[5:4];
                        m_mode = (m_mode / 4) * 4 + bus_wdata[1:0];
                    end
                    3'd1: begin
                        m_mode = (m_mode % 4) + (bus_wdata[3] ? 4 : 0);
                        m_sel  = bus_wdata[2:0];
                    end
                    3'd2: m_cmpa = bus_wdata;
                    3'd3: m_cmpb = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the reference
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (!rst && !done) begin
            chk("R6 model wave_a", wave_a, m_wa);
            chk("R6 model wave_b", wave_b, m_wb);
            chk("R5 model match_a", match_a, m_fa);
            chk("R5 model match_b", match_b, m_fb);
            chk("R9 model rdata", bus_rdata, m_read(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd4; bus_wdata = 8'h00;
    endtask

    task automatic rd(int a, output int v);
        bus_addr = 3'(a);
        #1;
        v = bus_rdata;
        bus_addr = 3'd4;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rate(int code, int edges, int exp, string tag);
        int c0, c1;
        wr(1, 8'(code));
        rd(4, c0);
        repeat (edges) @(negedge clk);
        rd(4, c1);
        chk(tag, (c1 - c0 + 256) % 256, exp);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog req=all actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, w0, pulses;
        do_reset();

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk("R1 reset read", v, 0);
        end
        chk("R1 reset wave_a", wave_a, 0);
        chk("R1 reset wave_b", wave_b, 0);
        chk("R1 reset match_a", match_a, 0);
        repeat (5) @(negedge clk);
        rd(4, v);
        chk("R1 stopped after reset", v, 0);

        // R9 reserved and readback fields
        wr(1, 8'h30);
        rd(1, v); chk("R9 ctl reserved bits", v, 0);
        wr(0, 8'h0C);
        rd(0, v); chk("R9 cfg bits 3:2", v, 0);
        wr(0, 8'h00);

        // R3 free-running wrap
        wr(1, 8'h01);
        repeat (300) @(negedge clk);
        rd(4, v); chk("R3 wrap count", v, 44);
        wr(1, 8'h00);
        rd(4, w0);
        repeat (20) @(negedge clk);
        rd(4, v); chk("R2 stopped code 0", v, w0);

        // R6 / R5 compare actions in free-running mode
        wr(2, 8'((w0 + 40) % 256));
        wr(3, 8'((w0 + 5) % 256));
        wr(0, 8'h70);                 // A toggle, B drive high
        wr(1, 8'h01);
        repeat (12) @(negedge clk);
        chk("R6 set on match B", wave_b, 1);
        wr(0, 8'h60);                 // A toggle, B drive low
        w0 = wave_a;
        pulses = 0;
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            if (match_a) pulses++;
        end
        chk("R5 pulses over two wraps", pulses, 2);
        chk("R6 toggle twice restores", wave_a, w0);
        chk("R6 clear on match B", wave_b, 0);

        // R2 prescaler ratios
        rate(1, 100, 100, "R2 code 1");
        rate(2, 80, 10, "R2 code 2 div8");
        rate(3, 640, 10, "R2 code 3 div64");
        rate(4, 2560, 10, "R2 code 4 div256");
        rate(5, 10240, 10, "R2 code 5 div1024");
        rate(6, 500, 0, "R2 code 6 stopped");
        rate(7, 500, 0, "R2 code 7 stopped");

        // R4 clear-on-compare period
        do_reset();
        wr(2, 8'd9);
        wr(0, 8'h02);
        wr(1, 8'h01);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (match_a) pulses++;
            rd(4, v);
            if (v > 9) chk("R4 count above top", v, 9);
        end
        chk("R4 pulses in 200 cycles", pulses, 20);

        // R7 force in stopped free-running mode
        do_reset();
        wr(0, 8'h70);                 // A toggle, B drive high
        wr(1, 8'hC0);
        chk("R7 force A toggles", wave_a, 1);
        chk("R7 force B sets", wave_b, 1);
        chk("R7 force no match_a", match_a, 0);
        chk("R7 force no match_b", match_b, 0);
        rd(4, v); chk("R7 force leaves count", v, 0);
        rd(1, v); chk("R9 force bits read zero", v, 0);
        @(negedge clk);
        chk("R7 no late match_a", match_a, 0);
        wr(1, 8'h80);
        chk("R7 second force toggles back", wave_a, 0);

        // R7 force in clear-on-compare does not clear the count
        wr(2, 8'd200);
        wr(0, 8'h42);                 // CTC, A toggle
        wr(1, 8'h01);
        repeat (50) @(negedge clk);
        rd(4, w0);
        wr(1, 8'h81);
        rd(4, v); chk("R7 CTC force keeps counting", v, (w0 + 2) % 256);
        chk("R7 CTC force toggles", wave_a, 1);

        // R8 pulse-width modes ignore force and hold pins
        wr(2, 8'd3);
        wr(0, 8'h51);                 // mode 001, both toggle
        w0 = wave_a;
        wr(1, 8'hC1);
        chk("R8 force ignored", wave_a, w0);
        pulses = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (match_a) pulses++;
        end
        chk("R8 pin held", wave_a, w0);
        chk("R5 pulses continue in pwm", pulses > 0, 1);

        // R10 gating uses the stored mode
        wr(1, 8'h08);                 // mode 100, stopped
        wr(0, 8'h40);                 // low bits 00, A toggle
        w0 = wave_a;
        wr(1, 8'h80);                 // force while clearing mode bit 2
        chk("R10 force gated by old mode", wave_a, w0);
        wr(1, 8'h80);
        chk("R10 force after mode change", wave_a, !w0);

        // R1 reset mid-run
        wr(1, 8'h01);
        do_reset();
        rd(4, v); chk("R1 re-reset count", v, 0);
        chk("R1 re-reset wave_a", wave_a, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule